// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the device-side end of a four-byte serial programming link. While the chip is held in programming mode through `prog_hold`, an external programmer drives `sck` and `mosi` and reads `miso`. The block takes `sck` and `mosi` into the fast system clock domain and finds the edges of `sck` there. It assembles bytes and acts on each complete four-byte instruction. The instructions are: programming enable, chip erase, byte write and byte read. They act on two register-based arrays, a program array and a data array, and each array has its own address space.

Before any other instruction has an effect, a programming-enable handshake must succeed. During the third byte of every instruction the block sends back the second byte it received, so the programmer can see whether framing is aligned. After a write or an erase the block stays busy for a fixed number of system clocks. During that time a read of an affected location returns 0xFF, and the programmer can poll on that value. A write never needs an erase first. New data replaces the old byte in one step.

Top module: `spt_target`

## Requirements
- R1: A `mosi` bit is taken on each rising edge of `sck`, most significant bit first. `miso` changes only after a falling edge of `sck`, and it shows bit 7 of each outgoing byte first. After reset `miso` is 0.
- R2: Every instruction is exactly four bytes long. A programming-enable instruction whose second byte is not 0x53 still uses up all four bytes and leaves the block disabled.
- R3: While the third byte of any instruction is being shifted in, `miso` carries the second byte of that instruction. For an aligned enable instruction this byte is 0x53. During the first and second bytes `miso` carries 0x00.
- R4: Programming enable is 0xAC, 0x53, any, any. Until it has succeeded, every other instruction has no effect, and the fourth byte on `miso` repeats the third input byte.
- R5: Chip erase (first byte 0xE0) sets every location of both arrays to 0xFF. After reset both arrays read 0xFF.
- R6: Program write is 0x40, addrHi, addrLo, data. Data write is 0xC0, addrHi, addrLo, data. The two arrays have separate address spaces, so a write to one array leaves the other array unchanged.
- R7: A data write replaces the old byte directly, with no erase needed first. Writing 0xC3 over 0x3C reads back 0xC3.
- R8: Program read is 0x20, addrHi, addrLo, any. Data read is 0xA0, addrHi, addrLo, any. Both return the addressed byte on `miso` during the fourth byte. The address is the low bits of {addrHi, addrLo}: 10 bits for 1024 program bytes and 7 bits for 128 data bytes.
- R9: A write or erase starts a busy window of BUSY_CYCLES system clocks. A read decided during that window returns 0xFF if it targets the written location or follows an erase. A read of any other location returns the real content.
- R10: A write or erase that completes while the busy window is open is ignored.
- R11: Dropping `prog_hold` disables the block and restarts byte framing. After this, a new programming-enable instruction is needed.
- R12: Transfers work when each `sck` phase lasts three or more system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_hold | input | 1 | High while the chip is held in programming mode |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |

## Verification
The embedded assertions run on every cycle. They check the following:
- `miso` and the receive register change only on the matching `sck` edge.
- A write or erase occurs only when the block is enabled and not busy.
- The busy counter loads and counts down as specified.
- Releasing `prog_hold` clears the enable.
- A poll hit returns 0xFF.

The values actually stored, the separate address spaces, the echo bytes, address truncation and framing recovery after a mid-byte release can only be shown by the bench's instruction sequences. The bench compares every returned byte against a behavioural model that also tracks the busy window in cycles.

// File: rtl/spt_pkg.sv
package spt_pkg;

    localparam logic [7:0] OP_ENABLE  = 8'hAC;
    localparam logic [7:0] SYNC_VALUE = 8'h53;
    localparam logic [7:0] OP_ERASE   = 8'hE0;
    localparam logic [7:0] OP_WR_PROG = 8'h40;
    localparam logic [7:0] OP_WR_DATA = 8'hC0;
    localparam logic [7:0] OP_RD_PROG = 8'h20;
    localparam logic [7:0] OP_RD_DATA = 8'hA0;
    localparam logic [7:0] BLANK      = 8'hFF;

    typedef struct packed {
        logic [2:0] bitc;
        logic [1:0] idx;
        logic [7:0] rx;
        logic [7:0] tx;
    } frame_t;

endpackage

// File: rtl/spt_edge.sv
module spt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic mosi_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_d, sck_q;
    logic [STAGES-1:0] dat_d, dat_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb begin
                sck_d = {sck_q[STAGES-2:0], sck_i};
                dat_d = {dat_q[STAGES-2:0], mosi_i};
            end
        end else begin : g_single
            always_comb begin
                sck_d = sck_i;
                dat_d = mosi_i;
            end
        end
    endgenerate

    always_comb prev_d = sck_q[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            dat_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            sck_q  <= sck_d;
            dat_q  <= dat_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sck_q[TOP] & ~prev_q;
    assign fall_o = ~sck_q[TOP] & prev_q;
    assign mosi_o = dat_q[TOP];

endmodule

// File: rtl/spt_frame.sv
module spt_frame
    import spt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_byte_i,
    output logic       miso_o,
    output logic       done_o,
    output logic [1:0] idx_o,
    output logic [7:0] rx_byte_o
);
    frame_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (clear_i) begin
            fr_d = '0;
        end else begin
            if (rise_i) begin
                fr_d.rx   = {fr_q.rx[6:0], mosi_i};
                fr_d.bitc = fr_q.bitc + 3'd1;
                if (fr_q.bitc == 3'd7) begin
                    fr_d.idx = fr_q.idx + 2'd1;
                end
            end
            if (fall_i) begin
                if (fr_q.bitc == 3'd0) begin
                    fr_d.tx = tx_byte_i;
                end else begin
                    fr_d.tx = {fr_q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign miso_o    = fr_q.tx[7];
    assign done_o    = rise_i && (fr_q.bitc == 3'd7) && !clear_i;
    assign idx_o     = fr_q.idx;
    assign rx_byte_o = {fr_q.rx[6:0], mosi_i};

    AST_MISO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_i && !clear_i) |=> $stable(miso_o)); // R1
    AST_RX_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !clear_i) |=> $stable(fr_q.rx)); // R1

endmodule

// File: rtl/spt_store.sv
module spt_store
    import spt_pkg::*;
#(
    parameter int PROG_DEPTH = 1024,
    parameter int DATA_DEPTH = 128,
    localparam int PA_W = $clog2(PROG_DEPTH),
    localparam int DA_W = $clog2(DATA_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            erase_i,
    input  logic            wr_prog_i,
    input  logic            wr_data_i,
    input  logic [PA_W-1:0] wr_paddr_i,
    input  logic [DA_W-1:0] wr_daddr_i,
    input  logic [7:0]      wr_val_i,
    input  logic [PA_W-1:0] rd_paddr_i,
    input  logic [DA_W-1:0] rd_daddr_i,
    output logic [7:0]      rd_pval_o,
    output logic [7:0]      rd_dval_o
);
    logic [7:0] prog_q [PROG_DEPTH];
    logic [7:0] data_q [DATA_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PROG_DEPTH; i++) prog_q[i] <= BLANK;
        end else if (erase_i) begin
            for (int i = 0; i < PROG_DEPTH; i++) prog_q[i] <= BLANK;
        end else if (wr_prog_i) begin
            prog_q[wr_paddr_i] <= wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_DEPTH; i++) data_q[i] <= BLANK;
        end else if (erase_i) begin
            for (int i = 0; i < DATA_DEPTH; i++) data_q[i] <= BLANK;
        end else if (wr_data_i) begin
            data_q[wr_daddr_i] <= wr_val_i;
        end
    end

    assign rd_pval_o = prog_q[rd_paddr_i];
    assign rd_dval_o = data_q[rd_daddr_i];

    AST_ERASE_BLANKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (prog_q[PROG_DEPTH-1] == BLANK && data_q[0] == BLANK)); // R5
    AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({erase_i, wr_prog_i, wr_data_i}) <= 1); // R6

endmodule

// File: rtl/spt_target.sv
module spt_target
    import spt_pkg::*;
#(
    parameter int PROG_DEPTH  = 1024,
    parameter int DATA_DEPTH  = 128,
    parameter int BUSY_CYCLES = 600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_hold,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int PA_W   = $clog2(PROG_DEPTH);
    localparam int DA_W   = $clog2(DATA_DEPTH);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [15:0] P_MASK = 16'(PROG_DEPTH - 1);
    localparam logic [15:0] D_MASK = 16'(DATA_DEPTH - 1);
    localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

    typedef struct packed {
        logic              enabled;
        logic [7:0]        b0;
        logic [7:0]        b1;
        logic [7:0]        b2;
        logic [7:0]        tx_next;
        logic              busy_all;
        logic              busy_data;
        logic [15:0]       busy_addr;
        logic [BUSY_W-1:0] busy_cnt;
    } ctl_t;

    function automatic logic [15:0] canon(input logic is_data, input logic [15:0] a);
        return is_data ? (a & D_MASK) : (a & P_MASK);
    endfunction

    ctl_t st_d, st_q;

    logic       rise, fall, mosi_s;
    logic       done;
    logic [1:0] idx;
    logic [7:0] rx_val;
    logic       busy, is_read, rd_data_sp, poll_hit;
    logic [15:0] rd_addr;
    logic [7:0]  rd_pval, rd_dval, rd_val;
    logic        erase, wr_prog, wr_data;
    logic [15:0] wr_addr;
    logic [7:0]  wr_val;

    spt_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck),
        .mosi_i (mosi),
        .rise_o (rise),
        .fall_o (fall),
        .mosi_o (mosi_s)
    );

    spt_frame i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (!prog_hold),
        .rise_i    (rise),
        .fall_i    (fall),
        .mosi_i    (mosi_s),
        .tx_byte_i (st_q.tx_next),
        .miso_o    (miso),
        .done_o    (done),
        .idx_o     (idx),
        .rx_byte_o (rx_val)
    );

    spt_store #(.PROG_DEPTH(PROG_DEPTH), .DATA_DEPTH(DATA_DEPTH)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_i    (erase),
        .wr_prog_i  (wr_prog),
        .wr_data_i  (wr_data),
        .wr_paddr_i (wr_addr[PA_W-1:0]),
        .wr_daddr_i (wr_addr[DA_W-1:0]),
        .wr_val_i   (wr_val),
        .rd_paddr_i (rd_addr[PA_W-1:0]),
        .rd_daddr_i (rd_addr[DA_W-1:0]),
        .rd_pval_o  (rd_pval),
        .rd_dval_o  (rd_dval)
    );

    // Read decision happens as the address byte completes.
    always_comb begin
        busy       = (st_q.busy_cnt != '0);
        is_read    = (st_q.b0 == OP_RD_PROG) || (st_q.b0 == OP_RD_DATA);
        rd_data_sp = (st_q.b0 == OP_RD_DATA);
        rd_addr    = canon(rd_data_sp, {st_q.b1, rx_val});
        rd_val     = rd_data_sp ? rd_dval : rd_pval;
        poll_hit   = busy && (st_q.busy_all ||
                     (st_q.busy_data == rd_data_sp && st_q.busy_addr == rd_addr));
    end

    always_comb begin
        st_d    = st_q;
        erase   = 1'b0;
        wr_prog = 1'b0;
        wr_data = 1'b0;
        wr_addr = canon(st_q.b0 == OP_WR_DATA, {st_q.b1, st_q.b2});
        wr_val  = rx_val;
        if (busy) st_d.busy_cnt = st_q.busy_cnt - 1'b1;
        if (!prog_hold) begin
            st_d.enabled = 1'b0;
            st_d.b0      = '0;
            st_d.b1      = '0;
            st_d.b2      = '0;
            st_d.tx_next = '0;
        end else if (done) begin
            unique case (idx)
                2'd0: begin
                    st_d.b0      = rx_val;
                    st_d.tx_next = 8'h00;
                end
                2'd1: begin
                    st_d.b1      = rx_val;
                    st_d.tx_next = rx_val;
                end
                2'd2: begin
                    st_d.b2      = rx_val;
                    st_d.tx_next = (st_q.enabled && is_read) ?
                                   (poll_hit ? BLANK : rd_val) : rx_val;
                end
                default: begin
                    st_d.tx_next = 8'h00;
                    if (st_q.b0 == OP_ENABLE && st_q.b1 == SYNC_VALUE) begin
                        st_d.enabled = 1'b1;
                    end else if (st_q.enabled && !busy) begin
                        if (st_q.b0 == OP_ERASE) begin
                            erase         = 1'b1;
                            st_d.busy_all = 1'b1;
                            st_d.busy_cnt = BUSY_LOAD;
                        end else if (st_q.b0 == OP_WR_PROG || st_q.b0 == OP_WR_DATA) begin
                            wr_prog        = (st_q.b0 == OP_WR_PROG);
                            wr_data        = (st_q.b0 == OP_WR_DATA);
                            st_d.busy_all  = 1'b0;
                            st_d.busy_data = wr_data;
                            st_d.busy_addr = wr_addr;
                            st_d.busy_cnt  = BUSY_LOAD;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prog || wr_data || erase) |-> st_q.enabled); // R4
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prog || wr_data || erase) |-> !busy); // R10
    AST_BUSY_STARTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prog || wr_data || erase) |=> st_q.busy_cnt == BUSY_LOAD); // R9
    AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> st_q.busy_cnt == $past(st_q.busy_cnt) - 1'b1); // R9
    AST_POLL_RETURNS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hold && done && idx == 2'd2 && st_q.enabled && is_read && poll_hit)
        |=> st_q.tx_next == BLANK); // R9
    AST_RELEASE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_hold |=> !st_q.enabled); // R11

endmodule

// File: tb/test_spt_target.sv
module test_spt_target;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 600;
    localparam logic [7:0] EN = 8'hAC, SY = 8'h53, ER = 8'hE0;
    localparam logic [7:0] WP = 8'h40, WD = 8'hC0, RP = 8'h20, RD = 8'hA0;

    logic clk = 1'b0, rst_n = 1'b0, prog_hold = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso;
    int cycle = 0, checks = 0, errors = 0, ph = 4, last_rise = 0;

    logic [7:0] prog_m [1024];
    logic [7:0] data_m [128];
    bit en_m = 0, bz_all = 0, bz_data = 0;
    int bz_addr = 0, t_busy = -1000000;

    spt_target #(.BUSY_CYCLES(BUSY)) i_spt_target (
        .clk(clk), .rst_n(rst_n), .prog_hold(prog_hold),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycle <= cycle + 1;
        if (cycle > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below 150000", cycle);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (ph) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            last_rise = cycle;
            repeat (ph) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    function automatic bit busy_at(input int t);
        return (t >= t_busy) && (t - t_busy < BUSY);
    endfunction

    task automatic run(input string req, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3);
        logic [7:0] r0, r1, r2, r3, e3;
        int t2, t3, a;
        bit dsp, hit;
        xbyte(b0, r0);
        xbyte(b1, r1);
        xbyte(b2, r2);
        t2 = last_rise;
        xbyte(b3, r3);
        t3 = last_rise;
        e3 = b2;
        if (en_m && (b0 == RP || b0 == RD)) begin
            dsp = (b0 == RD);
            a   = dsp ? ({b1, b2} & 16'h007F) : ({b1, b2} & 16'h03FF);
            hit = busy_at(t2) && (bz_all || (bz_data == dsp && bz_addr == a));
            e3  = hit ? 8'hFF : (dsp ? data_m[a] : prog_m[a]);
        end
        check({req, " byte0"}, r0, 8'h00);
        check({req, " byte1"}, r1, 8'h00);
        check({req, " byte2 echo"}, r2, b1);
        check({req, " byte3"}, r3, e3);
        if (b0 == EN && b1 == SY) begin
            en_m = 1;
        end else if (en_m && !busy_at(t3)) begin
            if (b0 == ER) begin
                foreach (prog_m[i]) prog_m[i] = 8'hFF;
                foreach (data_m[i]) data_m[i] = 8'hFF;
                bz_all = 1; t_busy = t3;
            end else if (b0 == WP || b0 == WD) begin
                dsp = (b0 == WD);
                a   = dsp ? ({b1, b2} & 16'h007F) : ({b1, b2} & 16'h03FF);
                if (dsp) data_m[a] = b3; else prog_m[a] = b3;
                bz_all = 0; bz_data = dsp; bz_addr = a; t_busy = t3;
            end
        end
    endtask

    initial begin
        logic [7:0] dummy;
        foreach (prog_m[i]) prog_m[i] = 8'hFF;
        foreach (data_m[i]) data_m[i] = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        prog_hold = 1'b1;
        idle(3);
        check("R1 reset miso", {7'd0, miso}, 8'h00);

        run("R4 write before enable", WP, 8'h00, 8'h05, 8'h12);
        run("R4 read before enable", RP, 8'h00, 8'h05, 8'h00);
        run("R2 bad enable", EN, 8'h52, 8'h00, 8'h00);
        run("R2 still disabled", RD, 8'h00, 8'h03, 8'h00);
        run("R3 good enable", EN, SY, 8'h00, 8'h00);
        run("R4 ignored write", RP, 8'h00, 8'h05, 8'h00);

        run("R6 data write", WD, 8'h00, 8'h07, 8'h3C);
        idle(BUSY + 50);
        run("R6 prog write", WP, 8'h00, 8'h07, 8'hA5);
        run("R6 other space", RD, 8'h00, 8'h07, 8'h00);
        run("R9 poll busy", RP, 8'h00, 8'h07, 8'h00);
        idle(BUSY + 50);
        run("R8 read prog", RP, 8'h00, 8'h07, 8'h00);

        run("R10 first write", WP, 8'h00, 8'h09, 8'h11);
        run("R10 write while busy", WP, 8'h00, 8'h0A, 8'h22);
        idle(BUSY + 50);
        run("R10 dropped write", RP, 8'h00, 8'h0A, 8'h00);
        run("R10 kept write", RP, 8'h00, 8'h09, 8'h00);

        run("R7 overwrite", WD, 8'h00, 8'h07, 8'hC3);
        idle(BUSY + 50);
        run("R7 readback", RD, 8'h00, 8'h07, 8'h00);

        run("R8 high address write", WP, 8'hFE, 8'h13, 8'h77);
        idle(BUSY + 50);
        run("R8 truncated read", RP, 8'h02, 8'h13, 8'h00);

        run("R5 erase", ER, 8'h00, 8'h00, 8'h00);
        run("R9 poll after erase", RD, 8'h00, 8'h07, 8'h00);
        idle(BUSY + 50);
        run("R5 prog blank", RP, 8'h00, 8'h07, 8'h00);
        run("R5 data blank", RD, 8'h00, 8'h07, 8'h00);
        run("R5 high prog blank", RP, 8'h02, 8'h13, 8'h00);

        run("R11 prepare", WP, 8'h00, 8'h01, 8'h5A);
        idle(BUSY + 50);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            repeat (ph) @(negedge clk);
            sck = 1'b1;
            repeat (ph) @(negedge clk);
            sck = 1'b0;
        end
        prog_hold = 1'b0;
        idle(5);
        en_m = 0;
        prog_hold = 1'b1;
        idle(5);
        run("R11 disabled after release", RP, 8'h00, 8'h01, 8'h00);
        run("R11 re-enable aligned", EN, SY, 8'h00, 8'h00);
        run("R11 read after re-enable", RP, 8'h00, 8'h01, 8'h00);

        ph = 3;
        run("R12 short phase write", WD, 8'h00, 8'h20, 8'h66);
        idle(BUSY + 50);
        run("R12 short phase read", RD, 8'h00, 8'h20, 8'h00);
        ph = 4;
        xbyte(8'h00, dummy);
        check("R1 idle byte after instruction", dummy, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule